// File: doc/BRIEF.md
# Keyed Configuration Port

This block is a byte-wide, I/O-mapped configuration window built from two adjacent addresses. The lower address is the index port and the next address up is the data port. The window is closed after reset. While it is closed, host software opens it by writing a fixed four-byte key to the index port.

Once the window is open, a byte written to the index port chooses an internal configuration register. A read or write at the data port then reaches that register.

The register set holds:
- a read-only 16-bit chip identifier, one byte per register;
- a logical-device selector;
- a flash-control byte, which is driven out to the rest of the chip;
- a 16-bit flash controller I/O base, split into two bytes, which is visible only while logical device 7 is selected.

Writing a specific value to a specific register closes the window again. A strap input places the port at one of two base addresses. The same strap also chooses the last byte of the key.

Top module: `cfg_port_unlock`

## Requirements
- R1: After reset the window is closed, `io_rdata` is 0xFF, `flash_ctl_o` is 0 and `flash_base_o` equals the parameter `FLASH_BASE_RST`.
- R2: The window opens when the bytes 0x87, 0x01 and 0x55 are written in a row to the index port, followed by a fourth byte. The fourth byte is 0x55 when `strap_alt`=0 (index port 0x2E, data port 0x2F) and 0xAA when `strap_alt`=1 (index port 0x4E, data port 0x4F). `cfg_open` rises on the clock edge that takes the fourth byte, and not before.
- R3: While the window is closed, an index-port byte that does not match the expected key byte restarts the key match. If that mismatching byte is 0x87, it counts as the first key byte.
- R4: While the window is closed, reads of the data port return 0xFF and writes to it change no register.
- R5: While the window is open, an index-port write latches the register number. A read of the index port returns that number. A read at either port loads `io_rdata` on the clock edge that samples `io_rd`.
- R6: Register 0x20 returns the high byte of `CHIP_ID` and register 0x21 returns the low byte. Writes to either register have no effect.
- R7: Register 0x07 is the read/write logical-device selector and resets to 0.
- R8: Registers 0x64 (high byte) and 0x65 (low byte) hold the flash controller base. They read back that base and accept writes only while the selector is 7. While the selector is any other value they read 0x00 and ignore writes. `flash_base_o` always shows the base.
- R9: Register 0x24 is the flash-control byte. Bits 5:0 are read/write and drive `flash_ctl_o`:
  - bit 0: suspend;
  - bits 3:1: segment enables;
  - bit 4: host flash write enable;
  - bit 5: pin selection.

  Bits 7:6 read 0.
- R10: Writing 0x02 to register 0x02 closes the window on that clock edge. Any other value written there leaves it open.
- R11: Accesses to any address other than the strapped index and data ports are ignored and leave `io_rdata` unchanged. Registers not named in R6 to R10 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Base/key strap, held static outside reset |
| io_addr | input | ADDR_W | Host I/O byte address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | Window is open |
| flash_ctl_o | output | 6 | Flash-control bits |
| flash_base_o | output | 16 | Flash controller I/O base |

## Verification
The bench builds the block with `FLASH_BASE_RST` = 0xA5C3. Because the two bytes of that value differ from each other and from 0x00, a swap of the high and low registers, or a leak of the base while another logical device is selected, shows up in the read data. `CHIP_ID` is left at 0x8716. The bench runs once with each value of `strap_alt`, and it resets between the two runs. This covers both base addresses and both fourth key bytes, and it makes the other strap's base act as a foreign address that must stay inert.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam logic [7:0] KEY_B0      = 8'h87;
  localparam logic [7:0] KEY_B1      = 8'h01;
  localparam logic [7:0] KEY_B2      = 8'h55;
  localparam logic [7:0] KEY_B3_PRI  = 8'h55;
  localparam logic [7:0] KEY_B3_ALT  = 8'hAA;
  localparam logic [7:0] PORT_PRI    = 8'h2E;
  localparam logic [7:0] PORT_ALT    = 8'h4E;

  localparam logic [7:0] RG_EXIT     = 8'h02;
  localparam logic [7:0] EXIT_CODE   = 8'h02;
  localparam logic [7:0] RG_LDSEL    = 8'h07;
  localparam logic [7:0] RG_ID_HI    = 8'h20;
  localparam logic [7:0] RG_ID_LO    = 8'h21;
  localparam logic [7:0] RG_FCTL     = 8'h24;
  localparam logic [7:0] RG_FBASE_HI = 8'h64;
  localparam logic [7:0] RG_FBASE_LO = 8'h65;
  localparam logic [7:0] FLASH_LDEV  = 8'h07;

  localparam int FCTL_W = 6;

  typedef enum logic [1:0] {
    KS_WAIT0 = 2'd0,
    KS_WAIT1 = 2'd1,
    KS_WAIT2 = 2'd2,
    KS_WAIT3 = 2'd3
  } key_step_e;

  function automatic logic [7:0] key_expect(key_step_e st, logic alt);
    case (st)
      KS_WAIT0: key_expect = KEY_B0;
      KS_WAIT1: key_expect = KEY_B1;
      KS_WAIT2: key_expect = KEY_B2;
      default:  key_expect = alt ? KEY_B3_ALT : KEY_B3_PRI;
    endcase
  endfunction

endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
  parameter int ADDR_W = 16
) (
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              hit_idx,
  output logic              hit_data
);
  import cfg_port_pkg::*;

  localparam int PAD_W = ADDR_W - 8;

  logic [ADDR_W-1:0] base_sel;
  logic [ADDR_W-1:0] data_sel;

  always_comb begin
    base_sel = {{PAD_W{1'b0}}, (strap_alt ? PORT_ALT : PORT_PRI)};
    data_sel = base_sel + {{(ADDR_W-1){1'b0}}, 1'b1};
    hit_idx  = (io_addr == base_sel);
    hit_data = (io_addr == data_sel);
  end

endmodule

// File: rtl/cfg_key_seq.sv
module cfg_key_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_alt,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       relock,
  output logic       cfg_open
);
  import cfg_port_pkg::*;

  key_step_e step_q, step_d;
  logic      open_q, open_d;
  logic      step_en;
  logic      hit;

  always_comb begin
    step_d  = step_q;
    open_d  = open_q;
    step_en = 1'b0;
    hit     = (key_byte == key_expect(step_q, strap_alt));
    if (relock) begin
      open_d  = 1'b0;
      step_d  = KS_WAIT0;
      step_en = 1'b1;
    end else if (key_wr && !open_q) begin
      step_en = 1'b1;
      if (hit) begin
        if (step_q == KS_WAIT3) begin
          open_d = 1'b1;
          step_d = KS_WAIT0;
        end else begin
          step_d = key_step_e'(step_q + 2'd1);
        end
      end else if (key_byte == KEY_B0) begin
        step_d = KS_WAIT1;
      end else begin
        step_d = KS_WAIT0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= KS_WAIT0;
      open_q <= 1'b0;
    end else if (step_en) begin
      step_q <= step_d;
      open_q <= open_d;
    end
  end

  assign cfg_open = open_q;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter logic [15:0] FLASH_BASE_RST = 16'h0290,
  parameter logic [15:0] CHIP_ID        = 16'h8716
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_open,
  input  logic                             idx_wr,
  input  logic                             data_wr,
  input  logic [7:0]                       wdata,
  output logic                             relock,
  output logic [7:0]                       idx_q,
  output logic [7:0]                       rd_byte,
  output logic [cfg_port_pkg::FCTL_W-1:0]  fctl_q,
  output logic [15:0]                      fbase_q
);
  import cfg_port_pkg::*;

  localparam int NBASE = 2;

  logic [7:0]        idx_d;
  logic              idx_en;
  logic [7:0]        ldsel_q, ldsel_d;
  logic              ldsel_en;
  logic [FCTL_W-1:0] fctl_d;
  logic              fctl_en;
  logic              flash_dev;
  logic [NBASE-1:0]  base_en;
  logic [7:0]        base_byte [NBASE];

  // index and data-port write enables
  always_comb begin
    idx_en    = idx_wr && cfg_open;
    idx_d     = wdata;
    flash_dev = (ldsel_q == FLASH_LDEV);
    ldsel_en  = data_wr && cfg_open && (idx_q == RG_LDSEL);
    ldsel_d   = wdata;
    fctl_en   = data_wr && cfg_open && (idx_q == RG_FCTL);
    fctl_d    = wdata[FCTL_W-1:0];
    relock    = data_wr && cfg_open && (idx_q == RG_EXIT) && (wdata == EXIT_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldsel_q <= 8'h00;
    end else if (ldsel_en) begin
      ldsel_q <= ldsel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fctl_q <= '0;
    end else if (fctl_en) begin
      fctl_q <= fctl_d;
    end
  end

  // base bytes: b=0 is the high byte, b=1 the low byte
  for (genvar b = 0; b < NBASE; b++) begin : g_base
    localparam logic [7:0] RG_NUM  = (b == 0) ? RG_FBASE_HI : RG_FBASE_LO;
    localparam logic [7:0] RST_VAL = (b == 0) ? FLASH_BASE_RST[15:8] : FLASH_BASE_RST[7:0];
    logic [7:0] byte_q;

    always_comb begin
      base_en[b] = data_wr && cfg_open && flash_dev && (idx_q == RG_NUM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= RST_VAL;
      end else if (base_en[b]) begin
        byte_q <= wdata;
      end
    end

    assign base_byte[b] = byte_q;
  end

  assign fbase_q = {base_byte[0], base_byte[1]};

  // read mux
  always_comb begin
    case (idx_q)
      RG_ID_HI:    rd_byte = CHIP_ID[15:8];
      RG_ID_LO:    rd_byte = CHIP_ID[7:0];
      RG_LDSEL:    rd_byte = ldsel_q;
      RG_FCTL:     rd_byte = {{(8-FCTL_W){1'b0}}, fctl_q};
      RG_FBASE_HI: rd_byte = flash_dev ? base_byte[0] : 8'h00;
      RG_FBASE_LO: rd_byte = flash_dev ? base_byte[1] : 8'h00;
      default:     rd_byte = 8'h00;
    endcase
  end

endmodule

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock #(
  parameter int          ADDR_W         = 16,
  parameter logic [15:0] FLASH_BASE_RST = 16'h0290,
  parameter logic [15:0] CHIP_ID        = 16'h8716
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_open,
  output logic [5:0]        flash_ctl_o,
  output logic [15:0]       flash_base_o
);
  import cfg_port_pkg::*;

  logic              hit_idx, hit_data;
  logic              relock;
  logic [7:0]        idx_q;
  logic [7:0]        rd_byte;
  logic [FCTL_W-1:0] fctl_q;
  logic [7:0]        rdata_q, rdata_d;
  logic              rdata_en;

  cfg_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .strap_alt (strap_alt),
    .io_addr   (io_addr),
    .hit_idx   (hit_idx),
    .hit_data  (hit_data)
  );

  cfg_key_seq u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_alt (strap_alt),
    .key_wr    (io_wr && hit_idx),
    .key_byte  (io_wdata),
    .relock    (relock),
    .cfg_open  (cfg_open)
  );

  cfg_reg_bank #(
    .FLASH_BASE_RST (FLASH_BASE_RST),
    .CHIP_ID        (CHIP_ID)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_open (cfg_open),
    .idx_wr   (io_wr && hit_idx),
    .data_wr  (io_wr && hit_data),
    .wdata    (io_wdata),
    .relock   (relock),
    .idx_q    (idx_q),
    .rd_byte  (rd_byte),
    .fctl_q   (fctl_q),
    .fbase_q  (flash_base_o)
  );

  always_comb begin
    rdata_en = io_rd && (hit_idx || hit_data);
    if (!cfg_open)     rdata_d = 8'hFF;
    else if (hit_idx)  rdata_d = idx_q;
    else               rdata_d = rd_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 8'hFF;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign io_rdata    = rdata_q;
  assign flash_ctl_o = fctl_q;

endmodule

// File: rtl/cfg_port_unlock_chk.sv
module cfg_port_unlock_chk #(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] CHIP_ID = 16'h8716
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_alt,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cfg_open,
  input logic [5:0]        flash_ctl_o,
  input logic [15:0]       flash_base_o,
  input logic [7:0]        idx_q
);
  logic [ADDR_W-1:0] ib, db;
  logic [7:0]        last_key;
  logic              at_idx, at_data;

  assign ib       = strap_alt ? ADDR_W'(16'h004E) : ADDR_W'(16'h002E);
  assign db       = ib + ADDR_W'(1);
  assign last_key = strap_alt ? 8'hAA : 8'h55;
  assign at_idx   = (io_addr == ib);
  assign at_data  = (io_addr == db);

  a_r2_open_needs_last_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && at_idx && io_wdata == last_key));

  a_r4_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd && at_data) |=> io_rdata == 8'hFF);

  a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_wr && at_data) |=> ($stable(flash_ctl_o) && $stable(flash_base_o)));

  a_r6_id_high_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_rd && at_data && idx_q == 8'h20) |=> io_rdata == CHIP_ID[15:8]);

  a_r10_exit_code_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && at_data && idx_q == 8'h02 && io_wdata == 8'h02) |=> !cfg_open);

  a_r11_foreign_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !at_idx && !at_data) |=> $stable(io_rdata));

endmodule

bind cfg_port_unlock cfg_port_unlock_chk #(.ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strap_alt    (strap_alt),
  .io_addr      (io_addr),
  .io_wr        (io_wr),
  .io_rd        (io_rd),
  .io_wdata     (io_wdata),
  .io_rdata     (io_rdata),
  .cfg_open     (cfg_open),
  .flash_ctl_o  (flash_ctl_o),
  .flash_base_o (flash_base_o),
  .idx_q        (idx_q)
);

// File: tb/cfg_port_unlock_tb.sv
module cfg_port_unlock_tb_top;

  localparam logic [15:0] FB  = 16'hA5C3;
  localparam logic [15:0] CID = 16'h8716;
  localparam int          WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_alt;
  logic [15:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        cfg_open;
  logic [5:0]  flash_ctl_o;
  logic [15:0] flash_base_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // model state
  bit         m_open;
  int         m_step;
  logic [7:0] m_idx, m_ldsel, m_rdata;
  logic [5:0] m_ctl;
  logic [15:0] m_base;

  always #10 clk = ~clk;

  cfg_port_unlock #(.ADDR_W(16), .FLASH_BASE_RST(FB), .CHIP_ID(CID)) dut_i (
    .clk, .rst_n, .strap_alt, .io_addr, .io_wr, .io_rd, .io_wdata,
    .io_rdata, .cfg_open, .flash_ctl_o, .flash_base_o
  );

  function automatic logic [15:0] ibase();
    return strap_alt ? 16'h004E : 16'h002E;
  endfunction

  function automatic logic [7:0] key_at(int s);
    case (s)
      0: return 8'h87;
      1: return 8'h01;
      2: return 8'h55;
      default: return strap_alt ? 8'hAA : 8'h55;
    endcase
  endfunction

  function automatic logic [7:0] m_reg();
    case (m_idx)
      8'h20: return CID[15:8];
      8'h21: return CID[7:0];
      8'h07: return m_ldsel;
      8'h24: return {2'b00, m_ctl};
      8'h64: return (m_ldsel == 8'h07) ? m_base[15:8] : 8'h00;
      8'h65: return (m_ldsel == 8'h07) ? m_base[7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk(req, "cfg_open", 32'(cfg_open), 32'(m_open));
    chk(req, "flash_ctl_o", 32'(flash_ctl_o), 32'(m_ctl));
    chk(req, "flash_base_o", 32'(flash_base_o), 32'(m_base));
  endtask

  task automatic do_reset(bit alt);
    @(negedge clk);
    rst_n = 1'b0; strap_alt = alt;
    io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0;
    m_open = 0; m_step = 0; m_idx = 0; m_ldsel = 0; m_ctl = 0;
    m_base = FB; m_rdata = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset rdata", 32'(io_rdata), 32'hFF);
    chk_state("R1");
  endtask

  task automatic do_wr(logic [15:0] a, logic [7:0] d, string req);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0;
    if (a == ibase()) begin
      if (!m_open) begin
        if (d == key_at(m_step)) begin
          if (m_step == 3) begin m_open = 1; m_step = 0; end
          else m_step++;
        end else m_step = (d == 8'h87) ? 1 : 0;
      end else m_idx = d;
    end else if (a == ibase() + 16'd1 && m_open) begin
      case (m_idx)
        8'h07: m_ldsel = d;
        8'h24: m_ctl = d[5:0];
        8'h64: if (m_ldsel == 8'h07) m_base[15:8] = d;
        8'h65: if (m_ldsel == 8'h07) m_base[7:0] = d;
        8'h02: if (d == 8'h02) m_open = 0;
        default: ;
      endcase
    end
    chk_state(req);
  endtask

  task automatic do_rd(logic [15:0] a, string req);
    io_addr = a; io_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_rd = 1'b0;
    if (a == ibase())              m_rdata = m_open ? m_idx : 8'hFF;
    else if (a == ibase() + 16'd1) m_rdata = m_open ? m_reg() : 8'hFF;
    chk(req, "io_rdata", 32'(io_rdata), 32'(m_rdata));
  endtask

  task automatic open_key(string req);
    for (int k = 0; k < 4; k++) do_wr(ibase(), key_at(k), req);
  endtask

  task automatic rd_reg(logic [7:0] r, string req);
    do_wr(ibase(), r, req);
    do_rd(ibase() + 16'd1, req);
  endtask

  task automatic wr_reg(logic [7:0] r, logic [7:0] d, string req);
    do_wr(ibase(), r, req);
    do_wr(ibase() + 16'd1, d, req);
  endtask

  task automatic directed();
    logic [15:0] other;
    other = strap_alt ? 16'h002E : 16'h004E;
    // R4: locked data port
    do_wr(ibase() + 16'd1, 8'h3F, "R4");
    do_rd(ibase() + 16'd1, "R4");
    // R2: wrong last byte (the other strap's) keeps it closed
    do_wr(ibase(), 8'h87, "R2"); do_wr(ibase(), 8'h01, "R2");
    do_wr(ibase(), 8'h55, "R2");
    do_wr(ibase(), strap_alt ? 8'h55 : 8'hAA, "R2");
    chk("R2", "wrong last key", 32'(cfg_open), 32'd0);
    // R11: key at the foreign base
    for (int k = 0; k < 4; k++) do_wr(other, key_at(k), "R11");
    chk("R11", "foreign key", 32'(cfg_open), 32'd0);
    // R3: broken by 0x33 then restart, and 0x87 mid-sequence restart
    do_wr(ibase(), 8'h87, "R3"); do_wr(ibase(), 8'h33, "R3");
    do_wr(ibase(), 8'h01, "R3"); do_wr(ibase(), 8'h55, "R3");
    do_wr(ibase(), key_at(3), "R3");
    chk("R3", "broken seq stays closed", 32'(cfg_open), 32'd0);
    do_wr(ibase(), 8'h87, "R3"); do_wr(ibase(), 8'h01, "R3");
    do_wr(ibase(), 8'h87, "R3"); do_wr(ibase(), 8'h01, "R3");
    do_wr(ibase(), 8'h55, "R3");
    chk("R2", "not open before last byte", 32'(cfg_open), 32'd0);
    do_wr(ibase(), key_at(3), "R3");
    chk("R3", "0x87 restart opens", 32'(cfg_open), 32'd1);
    // R5: index readback and foreign read
    do_wr(ibase(), 8'h5A, "R5");
    do_rd(ibase(), "R5");
    do_rd(16'h1234, "R11");
    rd_reg(8'h13, "R11");
    // R6
    rd_reg(8'h20, "R6"); rd_reg(8'h21, "R6");
    wr_reg(8'h20, 8'h00, "R6"); do_rd(ibase() + 16'd1, "R6");
    // R7 / R8
    rd_reg(8'h07, "R7");
    wr_reg(8'h07, 8'h03, "R7"); do_rd(ibase() + 16'd1, "R7");
    rd_reg(8'h64, "R8"); wr_reg(8'h65, 8'h11, "R8"); do_rd(ibase() + 16'd1, "R8");
    wr_reg(8'h07, 8'h07, "R8");
    rd_reg(8'h64, "R8"); rd_reg(8'h65, "R8");
    wr_reg(8'h64, 8'h3C, "R8"); do_rd(ibase() + 16'd1, "R8");
    // R9
    wr_reg(8'h24, 8'hFF, "R9"); do_rd(ibase() + 16'd1, "R9");
    wr_reg(8'h24, 8'h12, "R9"); do_rd(ibase() + 16'd1, "R9");
    // R10
    wr_reg(8'h02, 8'h01, "R10");
    chk("R10", "other value keeps open", 32'(cfg_open), 32'd1);
    wr_reg(8'h02, 8'h02, "R10");
    chk("R10", "exit code closes", 32'(cfg_open), 32'd0);
    do_rd(ibase() + 16'd1, "R4");
  endtask

  task automatic random_run(int n);
    logic [7:0] pool [12] = '{8'h87, 8'h01, 8'h55, 8'hAA, 8'h02, 8'h20,
                              8'h21, 8'h07, 8'h24, 8'h64, 8'h65, 8'h07};
    for (int i = 0; i < n; i++) begin
      int r;
      logic [15:0] a;
      logic [7:0] d;
      r = int'($urandom % 10);
      if (r < 4)      a = ibase();
      else if (r < 8) a = ibase() + 16'd1;
      else if (r < 9) a = strap_alt ? 16'h002E : 16'h004E;
      else            a = 16'($urandom);
      r = int'($urandom % 14);
      d = (r < 12) ? pool[r] : 8'($urandom);
      if (!m_open && ($urandom % 2) == 0) begin
        a = ibase(); d = key_at(m_step);
      end
      if (($urandom % 10) < 3) do_rd(a, "R5");
      else                     do_wr(a, d, "R2");
    end
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; strap_alt = 1'b0;
    io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0;
    do_reset(1'b0);
    directed();
    random_run(3000);
    do_reset(1'b1);
    directed();
    random_run(3000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule